// File: doc/BRIEF.md
# Power-Managed Clock Source Controller

This block decides which of three oscillators drives the system clock. The three candidates are a primary oscillator, a low-frequency secondary timer oscillator, and an internal oscillator block that has its own postscaler. Software writes a small control register with three fields: a two-bit source choice, a three-bit internal rate code, and an enable bit for the secondary oscillator. The source choice only takes effect when a sleep request strobe arrives and the device enters a power-managed mode. A wake request always brings the device back to the primary clock. The oscillators themselves are not part of the block. Each one appears only as a ready input: the primary start-up timer done, and the internal block stable.

The controller produces a one-hot source selection, the decoded internal rate (a low-frequency flag and a divide shift applied to 8 MHz), and three read-only status flags. These flags report whether the primary, the internal block or the secondary oscillator is currently supplying the clock. At most one flag is set at any time. All of them are clear while the device waits for an oscillator to become ready, and also while the slowest internal source is running.

The state machine has five states:
- `ST_PRI_WAIT`: on primary, start-up timer still running.
- `ST_PRI_RUN`: on primary, timer expired.
- `ST_SEC_RUN`: on the secondary oscillator.
- `ST_INT_WAIT`: on the internal block, not yet stable.
- `ST_INT_RUN`: on the internal block, stable.

Its transitions are:
- `wake` goes to `ST_PRI_WAIT` from any state other than `ST_PRI_RUN`. Wake has priority over sleep.
- `sleep_pri` goes from a secondary or internal state to `ST_PRI_WAIT`.
- `sleep_sec` goes to `ST_SEC_RUN`, but only when the enable bit is set. Otherwise the request is ignored.
- `sleep_int` goes from a primary or secondary state to `ST_INT_WAIT`.
- `ost_done` goes from `ST_PRI_WAIT` to `ST_PRI_RUN`.
- `int_ok` goes from `ST_INT_WAIT` to `ST_INT_RUN`.
- `int_lost` goes from `ST_INT_RUN` back to `ST_INT_WAIT`.

Top module: `clk_src_ctrl`

## Requirements
- R1: After reset, the source choice field reads primary, the rate code is 000, and the secondary enable is clear. `src_sel` is 3'b001 (bit 0 primary, bit 1 secondary, bit 2 internal), `int_lf_sel` is 1, and all status flags are clear.
- R2: Writing the source choice field without a sleep request leaves `src_sel` unchanged.
- R3: A sleep request with source choice 2'b10 or 2'b11 moves `src_sel` to 3'b100 on the next cycle. `stat_int` rises one cycle after `int_stable` is seen high, provided the rate code is not 000.
- R4: A sleep request with source choice 2'b01 while the secondary enable is set moves `src_sel` to 3'b010 on the next cycle, and `stat_sec` rises with it.
- R5: A sleep request with source choice 2'b01 while the secondary enable is clear is ignored. `src_sel` and all status flags keep their values.
- R6: The rate code decodes as follows. Code 111 gives `int_div_shift` 0 (undivided 8 MHz). Codes 110 down to 001 give shifts 1 to 6. Code 000 gives `int_lf_sel` 1. A write to the code changes these outputs on the cycle after the write, with no sleep request needed.
- R7: While the internal block is selected with rate code 000, all three status flags are clear, even when `int_stable` is high.
- R8: At most one of `stat_pri`, `stat_int` and `stat_sec` is set at any time.
- R9: A wake request moves `src_sel` to 3'b001 on the next cycle. `stat_pri` is set only once `pri_ost_done` has been seen high.
- R10: A sleep request with source choice 2'b00 taken from the internal or secondary source moves `src_sel` to 3'b001. `stat_pri` rises one cycle after `pri_ost_done` is high.
- R11: When a wake request and a sleep request arrive in the same cycle, the wake request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel_in | input | 2 | Source choice to write (00 primary, 01 secondary, 1x internal) |
| cfg_freq_in | input | 3 | Internal rate code to write |
| cfg_sec_en_in | input | 1 | Secondary oscillator enable to write |
| sleep_req | input | 1 | Sleep request strobe |
| wake_req | input | 1 | Wake request strobe |
| pri_ost_done | input | 1 | Primary start-up timer expired |
| int_stable | input | 1 | Internal oscillator block stable |
| src_sel | output | 3 | One-hot active source: bit0 primary, bit1 secondary, bit2 internal |
| int_lf_sel | output | 1 | Internal block outputs its low-frequency source |
| int_div_shift | output | 3 | Right shift applied to 8 MHz when not low-frequency |
| stat_pri | output | 1 | Primary is running after start-up |
| stat_int | output | 1 | Internal block is stable and running |
| stat_sec | output | 1 | Secondary oscillator is running |

## Verification
A corrupted state register shows up at `src_sel` on the cycle after the faulty transition, because the source selection is decoded straight from the state. A missed ready wait shows up at the status flags on the same cycle: a flag set while its ready input has never been high, or two flags set at once. A control register that latched the wrong value stays hidden until the next sleep request or rate write. At that point it surfaces one cycle later, either as an ignored secondary request that switched anyway, or as a rate decode that disagrees with the code that was written.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;
    localparam int SEL_W  = 2;
    localparam int FREQ_W = 3;
    localparam int SRC_N  = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_PRI = 2'b00,
        SEL_SEC = 2'b01,
        SEL_INT = 2'b10
    } sel_e;

    typedef enum logic [2:0] {
        ST_PRI_WAIT,
        ST_PRI_RUN,
        ST_SEC_RUN,
        ST_INT_WAIT,
        ST_INT_RUN
    } state_e;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [FREQ_W-1:0] freq;
        logic              sec_en;
    } cfg_t;
endpackage

// File: rtl/clk_src_cfg.sv
module clk_src_cfg
    import clk_src_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic [FREQ_W-1:0] freq_in,
    input  logic              sec_en_in,
    output cfg_t              cfg
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            cfg.sel    <= sel_in;
            cfg.freq   <= freq_in;
            cfg.sec_en <= sec_en_in;
        end
    end
endmodule

// File: rtl/clk_src_rate.sv
module clk_src_rate #(
    parameter int FREQ_W = 3
) (
    input  logic [FREQ_W-1:0] code,
    output logic              lf_sel,
    output logic [FREQ_W-1:0] div_shift
);
    localparam logic [FREQ_W-1:0] TOP_CODE = {FREQ_W{1'b1}};

    always_comb begin
        lf_sel    = (code == '0);
        div_shift = lf_sel ? '0 : FREQ_W'(TOP_CODE - code);
    end
endmodule

// File: rtl/clk_src_fsm.sv
module clk_src_fsm
    import clk_src_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             wake_req,
    input  logic [SEL_W-1:0] sel,
    input  logic             sec_en,
    input  logic             ost_done,
    input  logic             int_ok,
    input  logic             lf_sel,
    output logic [SRC_N-1:0] src_sel,
    output logic             stat_pri,
    output logic             stat_int,
    output logic             stat_sec
);
    state_e state_q, state_d;
    logic   on_pri, on_int;

    assign on_pri = (state_q == ST_PRI_WAIT) || (state_q == ST_PRI_RUN);
    assign on_int = (state_q == ST_INT_WAIT) || (state_q == ST_INT_RUN);

    always_comb begin
        state_d = state_q;
        if (wake_req) begin
            if (state_q != ST_PRI_RUN) state_d = ST_PRI_WAIT;
        end else if (sleep_req) begin
            if (sel[SEL_W-1]) begin
                if (!on_int) state_d = ST_INT_WAIT;
            end else if (sel[0]) begin
                if (sec_en) state_d = ST_SEC_RUN;
            end else begin
                if (!on_pri) state_d = ST_PRI_WAIT;
            end
        end else begin
            unique case (state_q)
                ST_PRI_WAIT: if (ost_done) state_d = ST_PRI_RUN;
                ST_INT_WAIT: if (int_ok)   state_d = ST_INT_RUN;
                ST_INT_RUN:  if (!int_ok)  state_d = ST_INT_WAIT;
                ST_PRI_RUN, ST_SEC_RUN: state_d = state_q;
                default: state_d = ST_PRI_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PRI_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        src_sel  = '0;
        stat_pri = 1'b0;
        stat_int = 1'b0;
        stat_sec = 1'b0;
        unique case (state_q)
            ST_PRI_WAIT: src_sel[0] = 1'b1;
            ST_PRI_RUN: begin
                src_sel[0] = 1'b1;
                stat_pri   = 1'b1;
            end
            ST_SEC_RUN: begin
                src_sel[1] = 1'b1;
                stat_sec   = 1'b1;
            end
            ST_INT_WAIT: src_sel[2] = 1'b1;
            ST_INT_RUN: begin
                src_sel[2] = 1'b1;
                stat_int   = !lf_sel;
            end
            default: src_sel[0] = 1'b1;
        endcase
    end
endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
    import clk_src_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel_in,
    input  logic [2:0]  cfg_freq_in,
    input  logic        cfg_sec_en_in,
    input  logic        sleep_req,
    input  logic        wake_req,
    input  logic        pri_ost_done,
    input  logic        int_stable,
    output logic [2:0]  src_sel,
    output logic        int_lf_sel,
    output logic [2:0]  int_div_shift,
    output logic        stat_pri,
    output logic        stat_int,
    output logic        stat_sec
);
    cfg_t             cfg_q;
    logic [SEL_W-1:0] cfg_sel;
    logic             cfg_sec_en;

    assign cfg_sel    = cfg_q.sel;
    assign cfg_sec_en = cfg_q.sec_en;

    clk_src_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .sel_in    (cfg_sel_in),
        .freq_in   (cfg_freq_in),
        .sec_en_in (cfg_sec_en_in),
        .cfg       (cfg_q)
    );

    clk_src_rate #(.FREQ_W(FREQ_W)) u_rate (
        .code      (cfg_q.freq),
        .lf_sel    (int_lf_sel),
        .div_shift (int_div_shift)
    );

    clk_src_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .wake_req  (wake_req),
        .sel       (cfg_q.sel),
        .sec_en    (cfg_q.sec_en),
        .ost_done  (pri_ost_done),
        .int_ok    (int_stable),
        .lf_sel    (int_lf_sel),
        .src_sel   (src_sel),
        .stat_pri  (stat_pri),
        .stat_int  (stat_int),
        .stat_sec  (stat_sec)
    );
endmodule

// File: rtl/clk_src_ctrl_chk.sv
module clk_src_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_req,
    input logic       wake_req,
    input logic       pri_ost_done,
    input logic       int_stable,
    input logic [1:0] cfg_sel,
    input logic       cfg_sec_en,
    input logic [2:0] src_sel,
    input logic       int_lf_sel,
    input logic       stat_pri,
    input logic       stat_int,
    input logic       stat_sec
);
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stat_pri, stat_int, stat_sec})); // R8

    AST_SRC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(src_sel) == 1); // R1

    AST_HOLD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_req && !wake_req) |=> $stable(src_sel)); // R2

    AST_SEC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !wake_req && cfg_sel == 2'b01 && !cfg_sec_en) |=> $stable(src_sel)); // R5

    AST_SEC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !wake_req && cfg_sel == 2'b01 && cfg_sec_en) |=> (src_sel == 3'b010 && stat_sec)); // R4

    AST_INT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !wake_req && cfg_sel[1]) |=> src_sel == 3'b100); // R3

    AST_WAKE_PRI: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> src_sel == 3'b001); // R11

    AST_LF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel[2] && int_lf_sel) |-> !(stat_pri || stat_int || stat_sec)); // R7

    AST_PRI_FLAG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_pri) |-> (src_sel == 3'b001 && $past(pri_ost_done))); // R9
endmodule

bind clk_src_ctrl clk_src_ctrl_chk u_chk (.*);

// File: tb/clk_src_ctrl_tb.sv
module clk_src_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel_in = '0;
    logic [2:0] cfg_freq_in = '0;
    logic       cfg_sec_en_in = 1'b0;
    logic       sleep_req = 1'b0;
    logic       wake_req = 1'b0;
    logic       pri_ost_done = 1'b0;
    logic       int_stable = 1'b0;
    logic [2:0] src_sel;
    logic       int_lf_sel;
    logic [2:0] int_div_shift;
    logic       stat_pri, stat_int, stat_sec;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    clk_src_ctrl dut_i (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int flags();
        return {29'd0, stat_pri, stat_int, stat_sec};
    endfunction

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [2:0] f, input logic e);
        cfg_we = 1'b1; cfg_sel_in = s; cfg_freq_in = f; cfg_sec_en_in = e;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic sleep_pulse();
        sleep_req = 1'b1; step(); sleep_req = 1'b0;
    endtask

    task automatic t_reset();
        chk(src_sel == 3'b001, "R1 src", src_sel, 1);
        chk(int_lf_sel == 1'b1, "R1 lf", int_lf_sel, 1);
        chk(flags() == 0, "R1 flags", flags(), 0);
        pri_ost_done = 1'b1; step();
        chk(flags() == 4, "R10 pri flag after ost", flags(), 4);
    endtask

    task automatic t_no_sleep();
        wr(2'b10, 3'b111, 1'b0); step(2);
        chk(src_sel == 3'b001, "R2 hold", src_sel, 1);
    endtask

    task automatic t_internal();
        int_stable = 1'b0;
        sleep_pulse();
        chk(src_sel == 3'b100, "R3 src", src_sel, 4);
        chk(flags() == 0, "R3 not stable", flags(), 0);
        int_stable = 1'b1; step();
        chk(flags() == 2, "R3 int flag", flags(), 2);
        for (int c = 7; c >= 1; c--) begin
            wr(2'b10, 3'(c), 1'b0);
            chk(int_div_shift == 3'(7 - c) && !int_lf_sel, "R6 shift", int_div_shift, 7 - c);
        end
        wr(2'b10, 3'b000, 1'b0);
        chk(int_lf_sel == 1'b1, "R6 lf", int_lf_sel, 1);
        chk(flags() == 0, "R7 lf flags clear", flags(), 0);
        chk(src_sel == 3'b100, "R6 no switch", src_sel, 4);
    endtask

    task automatic t_sec_ignored();
        wr(2'b01, 3'b000, 1'b0);
        sleep_pulse(); step();
        chk(src_sel == 3'b100, "R5 src", src_sel, 4);
        chk(flags() == 0, "R5 flags", flags(), 0);
    endtask

    task automatic t_sec_taken();
        wr(2'b01, 3'b101, 1'b1);
        sleep_pulse();
        chk(src_sel == 3'b010, "R4 src", src_sel, 2);
        chk(flags() == 1, "R4 flag", flags(), 1);
        chk($onehot0(flags()), "R8 exclusive", flags(), 1);
    endtask

    task automatic t_sleep_pri();
        pri_ost_done = 1'b0;
        wr(2'b00, 3'b101, 1'b1);
        sleep_pulse();
        chk(src_sel == 3'b001, "R10 src", src_sel, 1);
        chk(flags() == 0, "R10 wait ost", flags(), 0);
        pri_ost_done = 1'b1; step();
        chk(flags() == 4, "R10 pri flag", flags(), 4);
    endtask

    task automatic t_wake();
        wr(2'b11, 3'b101, 1'b1);
        sleep_pulse(); step();
        chk(flags() == 2, "R3 int again", flags(), 2);
        pri_ost_done = 1'b0;
        wake_req = 1'b1; step(); wake_req = 1'b0;
        chk(src_sel == 3'b001, "R9 src", src_sel, 1);
        step(2);
        chk(flags() == 0, "R9 no flag before ost", flags(), 0);
        pri_ost_done = 1'b1; step();
        chk(flags() == 4, "R9 pri flag", flags(), 4);
        sleep_pulse(); step();
        wake_req = 1'b1; sleep_req = 1'b1; step();
        wake_req = 1'b0; sleep_req = 1'b0;
        chk(src_sel == 3'b001, "R11 wake wins", src_sel, 1);
    endtask

    initial begin
        step(2);
        rst_n = 1'b1;
        step();
        t_reset();
        t_no_sleep();
        t_internal();
        t_sec_ignored();
        t_sec_taken();
        t_sleep_pri();
        t_wake();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #400000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule